// File: doc/BRIEF.md
# Phase-Interleaved PWM Timing Generator

This block drives the switching waveform of one converter channel. A shared sync line carries a master edge. Each channel counts its own period from the latest rising edge on that line. It switches on at a programmable fraction of that period, in steps of 1/32 turn, so that several channels on the same line switch at staggered times. A duty word fixes how many system clocks the output stays high in each period.

One 8-bit configuration byte sets the channel. The upper three bits choose the switching frequency from a table of eight entries that is not evenly spaced. The lower five bits give the phase step. The byte can always be read. A write is accepted only while the channel is disabled. At reset, the phase bits load either a 5-bit board address or zero, depending on a mode pin.

Top module: `pwm_il_top`

## Requirements
- R1: While rst_ni is low, the configuration byte takes the value {3'b000, mode_open_i ? addr_i : 5'd0}. rdata_o shows this value once reset is released.
- R2: rdata_o always shows the configuration byte. If wr_i is high while en_i is low, wdata_i is stored at that clock edge and appears on rdata_o after the edge.
- R3: If wr_i is high while en_i is high, the write is ignored and rdata_o keeps its previous value.
- R4: Bits 7:5 select the period in system clocks (60 MHz system clock): 000=120, 001=80, 010=60, 011=48, 100=48, 101=40, 110=34, 111=30.
- R5: The phase lag in clocks is floor(bits4:0 × period / 32), taken modulo the period. In the period that starts at a sync restart, the output first rises lag clocks after the restart.
- R6: A rising edge on sync_i, sampled at a clock edge, restarts the period counter at position 0 at that edge. With no sync edge, the counter wraps every period and runs freely.
- R7: When enabled, the output is high at counter positions p for which (p − lag) mod period < min(duty_i, period). A duty of 0 keeps the output low, and a duty of at least the period keeps it high.
- R8: pwm_o is low whenever en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_open_i | input | 1 | High: phase bits load from addr_i at reset |
| addr_i | input | 5 | Board address used as the reset phase position |
| en_i | input | 1 | Channel enable; also locks the configuration byte |
| wr_i | input | 1 | Single-cycle write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Current configuration byte |
| sync_i | input | 1 | Shared master sync line |
| duty_i | input | 8 | On-time in system clocks |
| pwm_o | output | 1 | PWM switching output |

## Verification
A write shows on rdata_o right after the edge that stores it. The bench reads it at the next falling edge. A sync edge sampled at clock edge E puts the counter at 0 after E, and pwm_o follows the counter with no further register. The monitor therefore compares the first expected item at the falling edge after E and continues one item per clock. The driver computes every item from the period table, the truncated lag and the clamped duty for position k mod period.

// File: rtl/pwm_il_pkg.sv
package pwm_il_pkg;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned POS_W = 5;
  localparam int unsigned CFG_W = SEL_W + POS_W;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [POS_W-1:0] pos;
  } cfg_t;

  // switching frequency in kHz per select code
  function automatic int unsigned sel_khz(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    return 500;
      3'd1:    return 750;
      3'd2:    return 1000;
      3'd3:    return 1250;
      3'd4:    return 1250;
      3'd5:    return 1500;
      3'd6:    return 1750;
      default: return 2000;
    endcase
  endfunction

  // rounded clocks per switching period
  function automatic int unsigned period_clks(input logic [SEL_W-1:0] sel,
                                              input int unsigned clk_khz);
    int unsigned f;
    f = sel_khz(sel);
    return (clk_khz + f / 2) / f;
  endfunction
endpackage

// File: rtl/pwm_il_cfg.sv
module pwm_il_cfg
  import pwm_il_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  mode_open_i,
  input  logic [POS_W-1:0]      addr_i,
  input  logic                  en_i,
  input  logic                  wr_i,
  input  logic [CFG_W-1:0]      wdata_i,
  output cfg_t                  cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.sel <= '0;
      cfg_q.pos <= mode_open_i ? addr_i : '0;
    end else if (wr_i && !en_i) begin
      cfg_q <= cfg_t'(wdata_i);
    end
  end

  assign cfg_o = cfg_q;

  a_r3_locked_when_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> $stable(cfg_q));
  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !en_i) |=> (cfg_q == $past(wdata_i)));
endmodule

// File: rtl/pwm_il_phase.sv
module pwm_il_phase
  import pwm_il_pkg::*;
#(
  parameter int unsigned CLK_KHZ = 60000,
  parameter int unsigned CNT_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cfg_t             cfg_i,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] lag_o
);
  localparam int unsigned PROD_W = CNT_W + POS_W;
  localparam int unsigned NSEL   = 1 << SEL_W;

  logic [CNT_W-1:0] per_tab [NSEL];
  logic [PROD_W-1:0] prod;
  logic [CNT_W-1:0]  raw;

  for (genvar s = 0; s < NSEL; s++) begin : g_tab
    assign per_tab[s] = CNT_W'(period_clks(SEL_W'(s), CLK_KHZ));
  end

  assign per_o = per_tab[cfg_i.sel];
  assign prod  = PROD_W'(per_o) * PROD_W'(cfg_i.pos);
  assign raw   = prod[PROD_W-1:POS_W];
  assign lag_o = (raw >= per_o) ? raw - per_o : raw;

  a_r5_lag_below_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lag_o < per_o);
endmodule

// File: rtl/pwm_il_core.sv
module pwm_il_core #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DUTY_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sync_i,
  input  logic [CNT_W-1:0]  per_i,
  input  logic [CNT_W-1:0]  lag_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);
  localparam int unsigned EXT_W = (CNT_W > DUTY_W ? CNT_W : DUTY_W) + 1;

  logic             sync_q;
  logic             sync_rise;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   rel;
  logic [EXT_W-1:0] duty_x, per_x, on_len;

  assign sync_rise = sync_i && !sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_i;
      if (sync_rise || (cnt_q >= per_i - 1'b1)) cnt_q <= '0;
      else                                       cnt_q <= cnt_q + 1'b1;
    end
  end

  // position relative to turn-on point, modulo period
  always_comb begin
    if (cnt_q >= lag_i) rel = {1'b0, cnt_q - lag_i};
    else                rel = {1'b0, cnt_q} + {1'b0, per_i} - {1'b0, lag_i};
  end

  assign duty_x = EXT_W'(duty_i);
  assign per_x  = EXT_W'(per_i);
  assign on_len = (duty_x > per_x) ? per_x : duty_x;
  assign pwm_o  = en_i && (EXT_W'(rel) < on_len);

  a_r6_sync_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_rise |=> (cnt_q == '0));
  a_r6_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(per_i) == per_i) |-> (cnt_q < per_i));
endmodule

// File: rtl/pwm_il_top.sv
module pwm_il_top
  import pwm_il_pkg::*;
#(
  parameter int unsigned CLK_KHZ = 60000,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned DUTY_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_open_i,
  input  logic [4:0]        addr_i,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              sync_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);
  cfg_t             cfg;
  logic [CNT_W-1:0] per, lag;

  pwm_il_cfg u_cfg (
    .clk_i, .rst_ni, .mode_open_i, .addr_i, .en_i, .wr_i, .wdata_i,
    .cfg_o(cfg)
  );

  pwm_il_phase #(.CLK_KHZ(CLK_KHZ), .CNT_W(CNT_W)) u_phase (
    .clk_i, .rst_ni, .cfg_i(cfg), .per_o(per), .lag_o(lag)
  );

  pwm_il_core #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_core (
    .clk_i, .rst_ni, .en_i, .sync_i, .per_i(per), .lag_i(lag), .duty_i,
    .pwm_o
  );

  assign rdata_o = cfg;

  a_r8_low_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !pwm_o);
endmodule

// File: tb/pwm_il_top_tb_top.sv
module pwm_il_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_open = 1'b1;
  logic [4:0] addr = 5'h13;
  logic       en = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sync = 1'b0;
  logic [7:0] duty = '0;
  logic       pwm;

  int checks = 0;
  int fails  = 0;
  bit go = 0;

  typedef struct { bit val; string req; } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  pwm_il_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_open_i(mode_open), .addr_i(addr),
    .en_i(en), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata),
    .sync_i(sync), .duty_i(duty), .pwm_o(pwm)
  );

  function automatic int exp_per(input int sel);
    int khz [8] = '{500, 750, 1000, 1250, 1250, 1500, 1750, 2000};
    return (60000 + khz[sel] / 2) / khz[sel];
  endfunction

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per falling edge
  always @(negedge clk) begin
    if (go && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (pwm !== it.val) begin
        fails++;
        $display("FAIL %s: actual=%b expected=%b at t=%0t", it.req, pwm, it.val, $time);
      end
    end
  end

  task automatic do_reset(input bit open, input logic [4:0] a);
    @(negedge clk);
    mode_open = open; addr = a; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  // driver: sync edge then expected samples for n cycles
  task automatic run_window(input bit on, input logic [7:0] cfg, input int d,
                            input int n, input string req);
    int per, lag, len;
    per = exp_per(cfg[7:5]);
    lag = (cfg[4:0] * per) / 32;
    if (lag >= per) lag = lag - per;
    len = (d > per) ? per : d;
    @(negedge clk);
    en = on; duty = 8'(d); sync = 1'b1;
    for (int k = 0; k < n; k++) begin
      item_t it;
      int p, rel;
      p = k % per;
      rel = (p >= lag) ? p - lag : p + per - lag;
      it.val = on && (rel < len);
      it.req = req;
      q.push_back(it);
    end
    @(posedge clk);
    #1 go = 1;
    @(negedge clk);
    sync = 1'b0;
    wait (q.size() == 0);
    go = 0;
    @(negedge clk);
    en = 1'b0;
  endtask

  initial begin : wdog
    #1000000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset(1'b1, 5'h13);
    chk8("R1 mode open", rdata, 8'h13);
    do_reset(1'b0, 5'h13);
    chk8("R1 mode low", rdata, 8'h00);

    write_cfg(8'h2C);
    chk8("R2 write while off", rdata, 8'h2C);

    // R4 R5 R6 R7 across the frequency table
    write_cfg(8'h00);
    run_window(1'b1, 8'h00, 30, 250, "R6 R7 sel0");
    write_cfg({3'd1, 5'd8});
    run_window(1'b1, {3'd1, 5'd8}, 10, 200, "R5 sel1 lag20");
    write_cfg({3'd3, 5'd31});
    run_window(1'b1, {3'd3, 5'd31}, 5, 120, "R5 R4 sel3 wrap");
    write_cfg({3'd4, 5'd31});
    run_window(1'b1, {3'd4, 5'd31}, 5, 120, "R4 sel4 equals sel3");
    write_cfg({3'd5, 5'd3});
    run_window(1'b1, {3'd5, 5'd3}, 200, 100, "R7 duty clamp");
    write_cfg({3'd6, 5'd7});
    run_window(1'b1, {3'd6, 5'd7}, 0, 80, "R7 duty zero");
    write_cfg({3'd7, 5'd16});
    run_window(1'b1, {3'd7, 5'd16}, 12, 100, "R4 R5 sel7");
    write_cfg({3'd2, 5'd1});
    run_window(1'b1, {3'd2, 5'd1}, 25, 150, "R5 R6 sel2");
    run_window(1'b0, {3'd2, 5'd1}, 25, 80, "R8 disabled");

    // R3: write attempt while enabled
    @(negedge clk);
    en = 1'b1;
    write_cfg(8'hFF);
    chk8("R3 write while on", rdata, {3'd2, 5'd1});
    @(negedge clk);
    en = 1'b0;
    chk8("R3 after enable drop", rdata, {3'd2, 5'd1});

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule